// File: doc/BRIEF.md
# Two-Channel Disk Host Register Block

This block is the software-visible register file of a two-channel disk host controller. A processor reaches it over a simple byte-addressed register bus that carries 1-, 2- and 4-byte reads and writes. For each channel it holds the following state:

- a bus-master command byte;
- a bus-master status byte, which has sticky, writable and read-only fields;
- a 6-bit scratch byte;
- a 12-bit serial control register;
- a masked interrupt-enable word;
- a configuration/status word that carries the channel's interrupt flag.

Two summary words gather both channels' command, interrupt and status bits into single reads. A link-status word per channel reports whether a device is present. A level interrupt output is the OR of the two channel flags.

A write to a serial control register with bit 0 set sends a one-cycle bus-reset pulse to that channel. The DMA engine supplies the status stub inputs: busy level, error pulse and drive interrupt level. Descriptor address registers and task-file registers are not implemented and read as zero.

Top module: `dcr_regfile`

## Requirements
- R1: After synchronous reset, the following are zero: every command, scratch, status, serial control and interrupt-enable register, `irq` and `bus_rst`. Each configuration word reads 0x6515_0000.
- R2: `rvalid` is high, and `rdata` holds the selected register, in the cycle after the cycle in which `rd_en` is sampled. `acc_size` (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) masks both the read data and the write data to the low bytes.
- R3: Channel 0 has its command byte at 0x00, scratch at 0x01 and status at 0x02. Channel 1 uses the same layout at 0x08, 0x09 and 0x0A. Offsets 0x03, 0x04-0x07, 0x0B and 0x0C-0x0F read zero. The scratch byte stores only bits 5:0 of a write.
- R4: A status write leaves the register at (w & 0x60) | (old & ~w & 0x06), and bits 7, 4 and 3 are always zero. Bit 0 follows the channel's `dma_busy` input every clock. Bit 1 is set by `dma_err` and bit 2 is set while `irq_in` is high. A set wins over a write-one clear in the same cycle.
- R5: Writes to command, scratch and status are also accepted at 0x10/0x11/0x12 for channel 0 and at 0x18/0x19/0x1A for channel 1. A read of 0x11 returns zero.
- R6: Offset 0x10 reads as the OR of these fields: channel 0 command in bits 7:0, channel 0 flag at bit 4, channel 1 flag at bit 6, channel 1 status bit 2 at bit 14, channel 0 status in bits 23:16 and channel 1 status in bits 31:24.
- R7: Offset 0x18 reads as the OR of these fields: channel 1 command in bits 7:0, channel 1 flag at bit 4 and channel 1 status in bits 23:16.
- R8: The configuration word is at 0xA0 for channel 0 and at 0xE0 for channel 1. Bits 31:16 are 0x6515. Bit 11 is the channel flag, which copies that channel's `irq_in` one clock later.
- R9: `irq` is the OR of the two channel flags.
- R10: Serial control is at 0x100 for channel 0 and at 0x180 for channel 1, and keeps bits 11:0. A write with bit 0 set drives that channel's `bus_rst` high for exactly the cycle after the write.
- R11: Interrupt enable is at 0x148 for channel 0 and at 0x1C8 for channel 1. It stores write bits 31:16 ANDed with 0x3EED and reads back in bits 31:16.
- R12: Link status is at 0x104 for channel 0 and at 0x184 for channel 1. It reads 0x113 when that channel's `dev_present` bit is high, and 0 otherwise.
- R13: Reads of every other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 9 | Byte offset |
| acc_size | input | 2 | Access width code |
| wdata | input | 32 | Write value, right-aligned |
| irq_in | input | 2 | Per-channel drive interrupt level |
| dev_present | input | 2 | Per-channel device present |
| dma_busy | input | 2 | Per-channel DMA active level (status bit 0) |
| dma_err | input | 2 | Per-channel DMA error pulse (status bit 1) |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid |
| irq | output | 1 | Level interrupt |
| bus_rst | output | 2 | Per-channel bus-reset pulse |

## Verification
The bench covers the mixed status fields. A design that stores the written bit 1 instead of clearing it, lets software overwrite the busy bit, or keeps bits 7, 4 and 3 would read back a wrong status after the write sequences. It also targets the mirror write offsets and the mirror read at 0x11. A decoder that ignores the mirrors would leave the registers unchanged, and one that maps the mirrors for reads would return data where zero is expected. The summary words are read with both channels holding different values, so a swapped channel or a misplaced bit changes the packed result. The bench also checks the bus-reset pulse width, the enable mask and the masking of narrow accesses.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int NCH      = 2;
    localparam int ADDR_W   = 9;
    localparam int DATA_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int SCR_W    = 6;
    localparam int SCTL_W   = 12;
    localparam int IEN_W    = 16;

    localparam logic [BYTE_W-1:0] STS_RW_MASK  = 8'h60;
    localparam logic [BYTE_W-1:0] STS_W1C_MASK = 8'h06;
    localparam logic [IEN_W-1:0]  IEN_MASK     = 16'h3EED;
    localparam logic [15:0]       CONF_ID      = 16'h6515;
    localparam logic [DATA_W-1:0] LINK_UP      = 32'h0000_0113;
    localparam int                CONF_FLAG_B  = 11;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [SCR_W-1:0]  scratch;
        logic [BYTE_W-1:0] status;
        logic [SCTL_W-1:0] sctl;
        logic [IEN_W-1:0]  ien;
        logic              flag;
    } chan_state_t;

    typedef struct packed {
        logic cmd;
        logic scratch;
        logic status;
        logic sctl;
        logic ien;
    } chan_wr_t;

    function automatic logic [ADDR_W-1:0] bm_base(input int c);
        return ADDR_W'(c * 8);
    endfunction
    function automatic logic [ADDR_W-1:0] mirror_base(input int c);
        return ADDR_W'(16 + c * 8);
    endfunction
    function automatic logic [ADDR_W-1:0] conf_off(input int c);
        return ADDR_W'(12'h0A0 + c * 12'h040);
    endfunction
    function automatic logic [ADDR_W-1:0] sctl_off(input int c);
        return ADDR_W'(12'h100 + c * 12'h080);
    endfunction
    function automatic logic [ADDR_W-1:0] link_off(input int c);
        return ADDR_W'(12'h104 + c * 12'h080);
    endfunction
    function automatic logic [ADDR_W-1:0] ien_off(input int c);
        return ADDR_W'(12'h148 + c * 12'h080);
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        logic m;
        m = (a == 9'h010) || (a == 9'h018);
        for (int c = 0; c < NCH; c++) begin
            if (a == bm_base(c) || a == bm_base(c) + 1 || a == bm_base(c) + 2 ||
                a == conf_off(c) || a == sctl_off(c) || a == link_off(c) ||
                a == ien_off(c))
                m = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/dcr_wr_decode.sv
module dcr_wr_decode
    import dcr_pkg::*;
(
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    output chan_wr_t [NCH-1:0]     wr
);
    for (genvar c = 0; c < NCH; c++) begin : g_dec
        always_comb begin
            wr[c].cmd     = wr_en && (addr == bm_base(c)     || addr == mirror_base(c));
            wr[c].scratch = wr_en && (addr == bm_base(c) + 1 || addr == mirror_base(c) + 1);
            wr[c].status  = wr_en && (addr == bm_base(c) + 2 || addr == mirror_base(c) + 2);
            wr[c].sctl    = wr_en && (addr == sctl_off(c));
            wr[c].ien     = wr_en && (addr == ien_off(c));
        end
    end
endmodule

// File: rtl/dcr_chan.sv
module dcr_chan
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wd,
    input  logic              irq_in,
    input  logic              busy,
    input  logic              err,
    output chan_state_t       st,
    output logic              bus_rst
);
    logic [BYTE_W-1:0] sts_n;

    always_comb begin
        sts_n = st.status;
        if (wr.status)
            sts_n = (wd[BYTE_W-1:0] & STS_RW_MASK) |
                    (st.status & ~wd[BYTE_W-1:0] & STS_W1C_MASK);
        sts_n[0] = busy;
        if (err)    sts_n[1] = 1'b1;
        if (irq_in) sts_n[2] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            bus_rst <= 1'b0;
        end else begin
            st.status <= sts_n;
            st.flag   <= irq_in;
            bus_rst   <= wr.sctl && wd[0];
            if (wr.cmd)     st.cmd     <= wd[BYTE_W-1:0];
            if (wr.scratch) st.scratch <= wd[SCR_W-1:0];
            if (wr.sctl)    st.sctl    <= wd[SCTL_W-1:0];
            if (wr.ien)     st.ien     <= wd[DATA_W-1 -: IEN_W] & IEN_MASK;
        end
    end
endmodule

// File: rtl/dcr_rd_mux.sv
module dcr_rd_mux
    import dcr_pkg::*;
(
    input  chan_state_t [NCH-1:0] st,
    input  logic [NCH-1:0]        present,
    input  logic [ADDR_W-1:0]     addr,
    output logic [DATA_W-1:0]     data
);
    always_comb begin
        data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == bm_base(c))     data = DATA_W'(st[c].cmd);
            if (addr == bm_base(c) + 1) data = DATA_W'(st[c].scratch);
            if (addr == bm_base(c) + 2) data = DATA_W'(st[c].status);
            if (addr == conf_off(c))    data = {CONF_ID, 4'h0, st[c].flag, 11'h0};
            if (addr == sctl_off(c))    data = DATA_W'(st[c].sctl);
            if (addr == link_off(c))    data = present[c] ? LINK_UP : '0;
            if (addr == ien_off(c))     data = {st[c].ien, 16'h0};
        end
        if (addr == 9'h010)
            data = {st[1].status, st[0].status, 8'h00, st[0].cmd} |
                   (DATA_W'(st[0].flag) << 4) |
                   (DATA_W'(st[1].flag) << 6) |
                   (DATA_W'(st[1].status[2]) << 14);
        if (addr == 9'h018)
            data = {8'h00, st[1].status, 8'h00, st[1].cmd} |
                   (DATA_W'(st[1].flag) << 4);
    end
endmodule

// File: rtl/dcr_regfile.sv
module dcr_regfile
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [8:0]        addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       wdata,
    input  logic [1:0]        irq_in,
    input  logic [1:0]        dev_present,
    input  logic [1:0]        dma_busy,
    input  logic [1:0]        dma_err,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic              irq,
    output logic [1:0]        bus_rst
);
    logic [DATA_W-1:0]      wd;
    logic [DATA_W-1:0]      rd_mux;
    chan_wr_t [NCH-1:0]     wr;
    chan_state_t [NCH-1:0]  st;
    logic [NCH-1:0]         flags;

    assign wd = wdata & size_mask(acc_size);

    dcr_wr_decode u_dec (.wr_en(wr_en), .addr(addr), .wr(wr));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dcr_chan u_ch (
            .clk(clk), .rst(rst), .wr(wr[c]), .wd(wd),
            .irq_in(irq_in[c]), .busy(dma_busy[c]), .err(dma_err[c]),
            .st(st[c]), .bus_rst(bus_rst[c])
        );
        assign flags[c] = st[c].flag;
    end

    dcr_rd_mux u_mux (.st(st), .present(dev_present), .addr(addr), .data(rd_mux));

    assign irq = |flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_mux & size_mask(acc_size);
        end
    end
endmodule

// File: rtl/dcr_regfile_chk.sv
module dcr_regfile_chk
    import dcr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic [8:0]  addr,
    input logic [1:0]  acc_size,
    input logic [31:0] wdata,
    input logic [1:0]  irq_in,
    input logic [31:0] rdata,
    input logic        rvalid,
    input logic        irq,
    input logic [1:0]  bus_rst
);
    // R2: read strobe is answered on the next cycle
    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    // R13: unmapped reads return zero
    a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !is_mapped($past(addr))) |-> rdata == '0);

    // R9: interrupt output tracks the drive inputs one clock later
    a_r9_irq_or: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq == $past(|irq_in));

    // R10: channel 0 bus reset only follows a serial control write with bit 0
    a_r10_busrst0_cause: assert property (@(posedge clk) disable iff (rst)
        bus_rst[0] |-> $past(wr_en && addr == 9'h100 && wdata[0]));

    // R10: channel 1 bus reset only follows a serial control write with bit 0
    a_r10_busrst1_cause: assert property (@(posedge clk) disable iff (rst)
        bus_rst[1] |-> $past(wr_en && addr == 9'h180 && wdata[0]));

    // R4: reserved status bits never read back as one
    a_r4_status_rsvd: assert property (@(posedge clk) disable iff (rst)
        (rvalid && ($past(addr) == 9'h002 || $past(addr) == 9'h00A)) |->
        (rdata[7] == 1'b0 && rdata[4:3] == 2'b00));

    // R8: identity field of configuration words
    a_r8_conf_id: assert property (@(posedge clk) disable iff (rst)
        (rvalid && $past(addr) == 9'h0A0 && $past(acc_size) >= 2'd2) |->
        rdata[31:16] == CONF_ID);
endmodule

bind dcr_regfile dcr_regfile_chk u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .acc_size(acc_size), .wdata(wdata), .irq_in(irq_in), .rdata(rdata),
    .rvalid(rvalid), .irq(irq), .bus_rst(bus_rst)
);

// File: tb/tb_dcr_regfile.sv
module tb_dcr_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [1:0]  acc_size = 2'd2;
    logic [31:0] wdata = '0;
    logic [1:0]  irq_in = '0, dev_present = '0, dma_busy = '0, dma_err = '0;
    logic [31:0] rdata;
    logic        rvalid, irq;
    logic [1:0]  bus_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dcr_regfile dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .acc_size(acc_size), .wdata(wdata), .irq_in(irq_in),
        .dev_present(dev_present), .dma_busy(dma_busy), .dma_err(dma_err),
        .rdata(rdata), .rvalid(rvalid), .irq(irq), .bus_rst(bus_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; acc_size = sz;
        @(negedge clk);
        wr_en = 1'b0; acc_size = 2'd2;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        rd_en = 1'b1; addr = a; acc_size = sz;
        @(negedge clk);
        rd_en = 1'b0; acc_size = 2'd2;
        d = rdata;
        n_chk++;
        if (rvalid !== 1'b1) begin
            n_bad++;
            $display("FAIL R2: actual rvalid %0b expected 1", rvalid);
        end
    endtask

    task automatic rd_check(input string req, input logic [8:0] a, input logic [31:0] exp,
                            input logic [1:0] sz = 2'd2);
        logic [31:0] v;
        rd(a, v, sz);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 cmd0", 9'h000, 32'h0);
        rd_check("R1 status0", 9'h002, 32'h0);
        rd_check("R1 conf0", 9'h0A0, 32'h6515_0000);
        rd_check("R1 conf1", 9'h0E0, 32'h6515_0000);
        rd_check("R1 sctl1", 9'h180, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 bus_rst", {30'h0, bus_rst}, 32'h0);
    endtask

    task automatic t_cmd_scratch;
        wr(9'h001, 32'hFF);
        rd_check("R3 scratch0 6 bits", 9'h001, 32'h3F);
        wr(9'h009, 32'h2A);
        rd_check("R3 scratch1", 9'h009, 32'h2A);
        wr(9'h000, 32'h09);
        rd_check("R3 cmd0", 9'h000, 32'h09);
        rd_check("R3 pad 0x03", 9'h003, 32'h0);
        rd_check("R3 prd stub 0x0C", 9'h00C, 32'h0);
    endtask

    task automatic t_status;
        @(negedge clk); dma_busy[0] = 1'b1; dma_err[0] = 1'b1;
        @(negedge clk); dma_err[0] = 1'b0;
        rd_check("R4 err+busy", 9'h002, 32'h03);
        wr(9'h002, 32'h62);
        rd_check("R4 w1c bit1, rw bits", 9'h002, 32'h61);
        @(negedge clk); dma_err[0] = 1'b1;
        @(negedge clk); dma_err[0] = 1'b0;
        wr(9'h002, 32'h04);
        rd_check("R4 bit1 kept, rw cleared", 9'h002, 32'h03);
        wr(9'h002, 32'hFF);
        rd_check("R4 reserved bits, bit0 ro", 9'h002, 32'h61);
        @(negedge clk); dma_err[0] = 1'b1;
        wr(9'h002, 32'h02);
        dma_err[0] = 1'b0;
        rd_check("R4 set beats clear", 9'h002, 32'h03);
        wr(9'h002, 32'h62);
        rd_check("R4 restore", 9'h002, 32'h61);
    endtask

    task automatic t_mirror;
        wr(9'h011, 32'h15);
        rd_check("R5 scratch0 via mirror", 9'h001, 32'h15);
        rd_check("R5 mirror read zero", 9'h011, 32'h0);
        wr(9'h018, 32'h05);
        rd_check("R5 cmd1 via mirror", 9'h008, 32'h05);
        @(negedge clk); dma_err[1] = 1'b1;
        @(negedge clk); dma_err[1] = 1'b0;
        wr(9'h01A, 32'h22);
        rd_check("R5 status1 via mirror", 9'h00A, 32'h20);
    endtask

    task automatic t_irq_summary;
        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk);
        check("R9 irq from ch1", {31'h0, irq}, 32'h1);
        rd_check("R8 conf1 flag", 9'h0E0, 32'h6515_0800);
        rd_check("R8 conf0 no flag", 9'h0A0, 32'h6515_0000);
        rd_check("R6 summary0", 9'h010, 32'h2461_4049);
        rd_check("R7 summary1", 9'h018, 32'h0024_0015);
        @(negedge clk); irq_in[1] = 1'b0;
        @(negedge clk);
        check("R9 irq drop", {31'h0, irq}, 32'h0);
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk); irq_in[0] = 1'b0;
        check("R9 irq from ch0 held by flag", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R8 flag follows input", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_sctl;
        wr(9'h100, 32'hFFFF_F001);
        check("R10 pulse ch0", {30'h0, bus_rst}, 32'h1);
        @(negedge clk);
        check("R10 pulse one cycle", {30'h0, bus_rst}, 32'h0);
        rd_check("R10 sctl0 12 bits", 9'h100, 32'h001);
        wr(9'h180, 32'h0ABC);
        check("R10 no pulse bit0 clear", {30'h0, bus_rst}, 32'h0);
        rd_check("R10 sctl1", 9'h180, 32'hABC);
    endtask

    task automatic t_ien_link;
        wr(9'h148, 32'hFFFF_0000);
        rd_check("R11 ien0 mask", 9'h148, 32'h3EED_0000);
        wr(9'h1C8, 32'h1234_5678);
        rd_check("R11 ien1 mask", 9'h1C8, 32'h1224_0000);
        @(negedge clk); dev_present = 2'b01;
        rd_check("R12 link0 up", 9'h104, 32'h113);
        rd_check("R12 link1 down", 9'h184, 32'h0);
    endtask

    task automatic t_size;
        rd_check("R2 byte read", 9'h0A0, 32'h0, 2'd0);
        rd_check("R2 half read", 9'h148, 32'h0, 2'd1);
        wr(9'h100, 32'h0FFF, 2'd0);
        check("R2 R10 narrow pulse", {30'h0, bus_rst}, 32'h1);
        rd_check("R2 narrow write", 9'h100, 32'h0FF, 2'd1);
    endtask

    task automatic t_unmapped;
        wr(9'h040, 32'hFFFF_FFFF);
        wr(9'h003, 32'hFF);
        wr(9'h1FC, 32'hFFFF_FFFF);
        rd_check("R13 read 0x40", 9'h040, 32'h0);
        rd_check("R13 read 0x1FC", 9'h1FC, 32'h0);
        rd_check("R13 cmd0 untouched", 9'h000, 32'h09);
        rd_check("R13 scratch0 untouched", 9'h001, 32'h15);
        rd_check("R13 ien0 untouched", 9'h148, 32'h3EED_0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cmd_scratch();
        t_status();
        t_mirror();
        t_irq_summary();
        t_sctl();
        t_ien_link();
        t_size();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule